// File: doc/BRIEF.md
# PCI Slot Hotplug Event Controller

This block records hot-add and hot-remove events for up to 32 PCI slots and raises a general-purpose event interrupt so that the operating system can find out which slot changed. A platform agent reports each event through a one-cycle strobe. The strobe carries a slot number and an event kind: cold-plug, hot-add or hot-remove. The block keeps an "arrived" mask and a "departed" mask and sets a hotplug status bit in a small byte-addressed event block. The interrupt request is asserted while that status bit and its enable bit are both set.

Software sees two register windows. The first is a 32-bit window holding the arrived mask, the departed mask, an eject command register and a read-only removable mask. The second is a 4-byte event window: status bytes, which are write-one-to-clear, followed by enable bytes. An eject command selects the lowest set bit of the written value. It emits a one-cycle eject pulse with the slot index, but only if that slot is removable. Removing the device and enumerating the bus are left to other logic.

Top module: `slot_hp_evtctl`

## Requirements
- R1: A hot-add event (kind code 1) clears both masks and then sets bit [slot] of the arrived mask, which reads at offset 0x0. The result is visible on the cycle after the strobe.
- R2: A hot-remove event (kind code 2) clears both masks and then sets bit [slot] of the departed mask, which reads at offset 0x4.
- R3: Every hot-add or hot-remove event sets bit 1 of event status byte 0 (event window byte address 0).
- R4: A cold-plug event (kind code 0) or a reserved kind (code 3) changes neither mask nor any status bit and raises no interrupt.
- R5: Software can write and read back the arrived mask at offset 0x0 and the departed mask at offset 0x4. Offset 0x8 reads zero, and any offset other than 0x0, 0x4 and 0xC reads zero.
- R6: A write to offset 0x8 selects the lowest set bit of the written value. If the removable mask has that bit set, the block drives a single-cycle eject pulse with that 5-bit slot index on the next cycle. A write of zero, or a selected slot that is not removable, produces no pulse.
- R7: The removable mask at offset 0xC is loaded during reset with all ones, with the bits set in the non-hotpluggable input cleared. Software writes to it have no effect.
- R8: Event window bytes 0 and 1 are status bytes and are write-one-to-clear. Bytes 2 and 3 are enable bytes and are plain read/write. All of them reset to zero.
- R9: The interrupt request is high exactly while bit 1 of status byte 0 and bit 1 of enable byte 2 are both set.
- R10: If a hotplug event and a software write to a mask, or a write-one-to-clear of the status bit, fall in the same cycle, the event result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Hotplug event strobe |
| evt_slot | input | 5 | Slot number of the event |
| evt_kind | input | 2 | 0 cold-plug, 1 hot-add, 2 hot-remove, 3 reserved |
| fixed_mask | input | 32 | Per-slot not-hotpluggable flags, sampled during reset |
| hp_addr | input | 4 | Byte offset in the 32-bit register window |
| hp_wr | input | 1 | Write strobe for the register window |
| hp_wdata | input | 32 | Write data for the register window |
| hp_rdata | output | 32 | Read data for hp_addr (combinational) |
| gpe_addr | input | 2 | Byte address in the event window |
| gpe_wr | input | 1 | Write strobe for the event window |
| gpe_wdata | input | 8 | Write data for the event window |
| gpe_rdata | output | 8 | Read data for gpe_addr (combinational) |
| irq | output | 1 | Event interrupt request |
| ej_valid | output | 1 | Eject pulse |
| ej_slot | output | 5 | Slot index carried by the eject pulse |

## Verification
The event path is driven with a hot-add followed by a hot-remove, which shows that each event wipes the mask the previous one set. It is also driven with cold-plug and reserved kinds, which shows that suppressed events leave the state alone, and with events that land in the same cycle as software writes, which exposes the precedence rule. Eject writes use a single bit, several bits whose lowest bit is not removable, zero, and the top slot. This separates the lowest-bit selection from the removable gating. The interrupt is checked with the enable bit clear and with it set, and before and after a write-one-to-clear. This separates the status path from the enable path.

// File: rtl/slot_hp_pkg.sv
package slot_hp_pkg;
   typedef enum logic [1:0] {
      KIND_COLD   = 2'd0,
      KIND_ADD    = 2'd1,
      KIND_REMOVE = 2'd2,
      KIND_RSVD   = 2'd3
   } hp_kind_e;

   localparam int REG_W      = 32;
   localparam int WIN_AW     = 4;
   localparam logic [WIN_AW-1:0] OFS_ARRIVED  = 4'h0;
   localparam logic [WIN_AW-1:0] OFS_DEPARTED = 4'h4;
   localparam logic [WIN_AW-1:0] OFS_EJECT    = 4'h8;
   localparam logic [WIN_AW-1:0] OFS_REMOVE   = 4'hC;
endpackage

// File: rtl/slot_hp_masks.sv
module slot_hp_masks #(
   parameter int NSLOT  = 32,
   parameter int SLOT_W = $clog2(NSLOT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hot_evt,
   input  logic              hot_add,
   input  logic [SLOT_W-1:0] hot_slot,
   input  logic              sw_wr_arr,
   input  logic              sw_wr_dep,
   input  logic [NSLOT-1:0]  sw_wdata,
   output logic [NSLOT-1:0]  arrived,
   output logic [NSLOT-1:0]  departed
);
   logic [NSLOT-1:0] slot_bit;

   initial begin
      assert (NSLOT >= 2 && NSLOT <= 32) else $error("NSLOT out of range");
   end

   always_comb begin
      slot_bit = '0;
      slot_bit[hot_slot] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arrived  <= '0;
         departed <= '0;
      end else if (hot_evt) begin
         arrived  <= hot_add ? slot_bit : '0;
         departed <= hot_add ? '0 : slot_bit;
      end else begin
         if (sw_wr_arr) arrived  <= sw_wdata;
         if (sw_wr_dep) departed <= sw_wdata;
      end
   end

   a_r1_add_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      (hot_evt && hot_add) |=> ($countones(arrived) == 1 && departed == '0));
   a_r2_remove_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      (hot_evt && !hot_add) |=> ($countones(departed) == 1 && arrived == '0));
   a_r4_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!hot_evt && !sw_wr_arr && !sw_wr_dep) |=> ($stable(arrived) && $stable(departed)));
endmodule

// File: rtl/slot_hp_eject.sv
module slot_hp_eject #(
   parameter int NSLOT  = 32,
   parameter int SLOT_W = $clog2(NSLOT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [NSLOT-1:0]  cmd_data,
   input  logic [NSLOT-1:0]  removable,
   output logic              ej_valid,
   output logic [SLOT_W-1:0] ej_slot
);
   logic [SLOT_W-1:0] low_idx;
   logic              any_bit;

   always_comb begin
      low_idx = '0;
      for (int i = NSLOT - 1; i >= 0; i--) begin
         if (cmd_data[i]) low_idx = SLOT_W'(i);
      end
      any_bit = |cmd_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ej_valid <= 1'b0;
         ej_slot  <= '0;
      end else begin
         ej_valid <= cmd_wr && any_bit && removable[low_idx];
         if (cmd_wr) ej_slot <= low_idx;
      end
   end

   a_r6_only_removable: assert property (@(posedge clk) disable iff (!rst_n)
      ej_valid |-> removable[ej_slot]);
   a_r6_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      ej_valid |-> $past(cmd_wr));
endmodule

// File: rtl/slot_hp_gpe.sv
module slot_hp_gpe #(
   parameter int GPE_BYTES = 4,
   parameter int HP_BIT    = 1,
   parameter int GPE_AW    = $clog2(GPE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [GPE_AW-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic              hot_evt,
   output logic              irq
);
   localparam int HALF = GPE_BYTES / 2;

   logic [7:0] sts_q [HALF];
   logic [7:0] en_q  [HALF];

   initial begin
      assert (GPE_BYTES >= 2 && GPE_BYTES % 2 == 0) else $error("GPE_BYTES must be even");
      assert (HP_BIT >= 0 && HP_BIT < 8) else $error("HP_BIT out of range");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < HALF; b++) begin
            sts_q[b] <= '0;
            en_q[b]  <= '0;
         end
      end else begin
         for (int b = 0; b < HALF; b++) begin
            logic [7:0] nxt;
            nxt = sts_q[b];
            if (wr && addr == GPE_AW'(b)) nxt = nxt & ~wdata;
            if (b == 0 && hot_evt) nxt[HP_BIT] = 1'b1;
            sts_q[b] <= nxt;
            if (wr && addr == GPE_AW'(HALF + b)) en_q[b] <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int b = 0; b < HALF; b++) begin
         if (addr == GPE_AW'(b))        rdata = sts_q[b];
         if (addr == GPE_AW'(HALF + b)) rdata = en_q[b];
      end
   end

   assign irq = sts_q[0][HP_BIT] & en_q[0][HP_BIT];

   a_r3_event_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
      hot_evt |=> sts_q[0][HP_BIT]);
   a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(hot_evt) || $past(wr)));
   a_r8_w1c_only: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts_q[0][HP_BIT]) |-> $past(wr));
endmodule

// File: rtl/slot_hp_evtctl.sv
module slot_hp_evtctl
   import slot_hp_pkg::*;
#(
   parameter int NSLOT     = 32,
   parameter int GPE_BYTES = 4,
   parameter int HP_BIT    = 1,
   parameter int SLOT_W    = $clog2(NSLOT),
   parameter int GPE_AW    = $clog2(GPE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   input  logic [SLOT_W-1:0] evt_slot,
   input  logic [1:0]        evt_kind,
   input  logic [NSLOT-1:0]  fixed_mask,
   input  logic [WIN_AW-1:0] hp_addr,
   input  logic              hp_wr,
   input  logic [REG_W-1:0]  hp_wdata,
   output logic [REG_W-1:0]  hp_rdata,
   input  logic [GPE_AW-1:0] gpe_addr,
   input  logic              gpe_wr,
   input  logic [7:0]        gpe_wdata,
   output logic [7:0]        gpe_rdata,
   output logic              irq,
   output logic              ej_valid,
   output logic [SLOT_W-1:0] ej_slot
);
   logic             hot_evt, hot_add;
   logic [NSLOT-1:0] arrived, departed, removable_q;

   initial begin
      assert (NSLOT <= REG_W) else $error("NSLOT wider than register");
   end

   assign hot_evt = evt_valid && (evt_kind == KIND_ADD || evt_kind == KIND_REMOVE);
   assign hot_add = (evt_kind == KIND_ADD);

   always_ff @(posedge clk) begin
      if (!rst_n) removable_q <= ~fixed_mask;
   end

   slot_hp_masks #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_masks (
      .clk       (clk),
      .rst_n     (rst_n),
      .hot_evt   (hot_evt),
      .hot_add   (hot_add),
      .hot_slot  (evt_slot),
      .sw_wr_arr (hp_wr && hp_addr == OFS_ARRIVED),
      .sw_wr_dep (hp_wr && hp_addr == OFS_DEPARTED),
      .sw_wdata  (hp_wdata[NSLOT-1:0]),
      .arrived   (arrived),
      .departed  (departed)
   );

   slot_hp_eject #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_eject (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (hp_wr && hp_addr == OFS_EJECT),
      .cmd_data  (hp_wdata[NSLOT-1:0]),
      .removable (removable_q),
      .ej_valid  (ej_valid),
      .ej_slot   (ej_slot)
   );

   slot_hp_gpe #(.GPE_BYTES(GPE_BYTES), .HP_BIT(HP_BIT), .GPE_AW(GPE_AW)) u_gpe (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (gpe_wr),
      .addr    (gpe_addr),
      .wdata   (gpe_wdata),
      .rdata   (gpe_rdata),
      .hot_evt (hot_evt),
      .irq     (irq)
   );

   always_comb begin
      case (hp_addr)
         OFS_ARRIVED:  hp_rdata = REG_W'(arrived);
         OFS_DEPARTED: hp_rdata = REG_W'(departed);
         OFS_REMOVE:   hp_rdata = REG_W'(removable_q);
         default:      hp_rdata = '0;
      endcase
   end

   a_r7_removable_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(removable_q));
   a_r10_event_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
      (hot_evt && hot_add && hp_wr && hp_addr == OFS_ARRIVED) |=> $countones(arrived) == 1);
endmodule

// File: tb/slot_hp_evtctl_tb.sv
module slot_hp_evtctl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_valid = 1'b0;
   logic [4:0]  evt_slot = '0;
   logic [1:0]  evt_kind = '0;
   logic [31:0] fixed_mask = 32'h0000_0011;
   logic [3:0]  hp_addr = '0;
   logic        hp_wr = 1'b0;
   logic [31:0] hp_wdata = '0;
   logic [31:0] hp_rdata;
   logic [1:0]  gpe_addr = '0;
   logic        gpe_wr = 1'b0;
   logic [7:0]  gpe_wdata = '0;
   logic [7:0]  gpe_rdata;
   logic        irq, ej_valid;
   logic [4:0]  ej_slot;

   int n_chk = 0;
   int n_bad = 0;
   int exp_q[$];
   bit done = 0;

   always #2 clk = ~clk;

   slot_hp_evtctl u_dut (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_slot(evt_slot),
      .evt_kind(evt_kind), .fixed_mask(fixed_mask), .hp_addr(hp_addr),
      .hp_wr(hp_wr), .hp_wdata(hp_wdata), .hp_rdata(hp_rdata),
      .gpe_addr(gpe_addr), .gpe_wr(gpe_wr), .gpe_wdata(gpe_wdata),
      .gpe_rdata(gpe_rdata), .irq(irq), .ej_valid(ej_valid), .ej_slot(ej_slot)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd_hp(input logic [3:0] a, input logic [31:0] exp, input string req);
      hp_addr = a; #1;
      chk(req, hp_rdata, exp);
   endtask

   task automatic rd_gpe(input logic [1:0] a, input logic [7:0] exp, input string req);
      gpe_addr = a; #1;
      chk(req, {24'h0, gpe_rdata}, {24'h0, exp});
   endtask

   task automatic wr_hp(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); hp_addr = a; hp_wdata = d; hp_wr = 1'b1;
      @(negedge clk); hp_wr = 1'b0;
   endtask

   task automatic wr_gpe(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); gpe_addr = a; gpe_wdata = d; gpe_wr = 1'b1;
      @(negedge clk); gpe_wr = 1'b0;
   endtask

   task automatic event_in(input logic [4:0] s, input logic [1:0] k);
      @(negedge clk); evt_slot = s; evt_kind = k; evt_valid = 1'b1;
      @(negedge clk); evt_valid = 1'b0;
   endtask

   // driver: push the expected eject slot (or nothing) and issue the write
   task automatic eject(input logic [31:0] d, input int exp_slot);
      if (exp_slot >= 0) exp_q.push_back(exp_slot);
      wr_hp(4'h8, d);
      @(negedge clk); @(negedge clk);
   endtask

   // monitor: every eject pulse must match the head of the queue
   always @(negedge clk) begin
      if (rst_n && ej_valid) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R6 unexpected eject actual=%0d expected=none", ej_slot);
         end else begin
            int e;
            e = exp_q.pop_front();
            chk("R6 eject slot", {27'h0, ej_slot}, e);
         end
      end
   end

   initial begin
      #400000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      fixed_mask = 32'hFFFF_FFFF;   // later changes must be ignored (R7)
      @(negedge clk);
      // reset state
      rd_hp(4'h0, 32'h0, "R1 reset arrived");
      rd_hp(4'h4, 32'h0, "R2 reset departed");
      rd_hp(4'hC, 32'hFFFF_FFEE, "R7 removable reset");
      rd_gpe(2'd0, 8'h00, "R8 reset sts0");
      rd_gpe(2'd2, 8'h00, "R8 reset en0");
      chk("R9 reset irq", {31'h0, irq}, 32'h0);

      // cold and reserved kinds
      event_in(5'd3, 2'd0);
      rd_hp(4'h0, 32'h0, "R4 cold arrived");
      rd_gpe(2'd0, 8'h00, "R4 cold status");
      event_in(5'd3, 2'd3);
      rd_hp(4'h4, 32'h0, "R4 reserved departed");
      rd_gpe(2'd0, 8'h00, "R4 reserved status");

      // hot-add with enable off: status set, no irq
      event_in(5'd5, 2'd1);
      rd_hp(4'h0, 32'h0000_0020, "R1 add arrived");
      rd_hp(4'h4, 32'h0, "R1 add departed");
      rd_gpe(2'd0, 8'h02, "R3 add status");
      chk("R9 irq enable off", {31'h0, irq}, 32'h0);
      wr_gpe(2'd2, 8'h02);
      chk("R9 irq enable on", {31'h0, irq}, 32'h1);
      rd_gpe(2'd2, 8'h02, "R8 enable readback");

      // hot-remove wipes previous add
      event_in(5'd31, 2'd2);
      rd_hp(4'h0, 32'h0, "R2 remove arrived");
      rd_hp(4'h4, 32'h8000_0000, "R2 remove departed");
      chk("R3 irq after remove", {31'h0, irq}, 32'h1);

      // W1C
      wr_gpe(2'd0, 8'h01);
      rd_gpe(2'd0, 8'h02, "R8 w1c other bit");
      wr_gpe(2'd0, 8'h02);
      rd_gpe(2'd0, 8'h00, "R8 w1c clear");
      chk("R9 irq cleared", {31'h0, irq}, 32'h0);
      wr_gpe(2'd1, 8'hFF);
      rd_gpe(2'd1, 8'h00, "R8 status byte1");
      wr_gpe(2'd3, 8'h5A);
      rd_gpe(2'd3, 8'h5A, "R8 enable byte3");

      // software access
      wr_hp(4'h0, 32'hA5A5_1234);
      rd_hp(4'h0, 32'hA5A5_1234, "R5 arrived rw");
      wr_hp(4'h4, 32'h0F0F_0001);
      rd_hp(4'h4, 32'h0F0F_0001, "R5 departed rw");
      rd_hp(4'h8, 32'h0, "R5 eject reads zero");
      rd_hp(4'h2, 32'h0, "R5 unmapped reads zero");
      wr_hp(4'hC, 32'h0);
      rd_hp(4'hC, 32'hFFFF_FFEE, "R7 removable write ignored");

      // eject cases
      eject(32'h0000_0060, 5);
      eject(32'h0000_0010, -1);
      eject(32'h0000_0011, -1);
      eject(32'h0000_0000, -1);
      eject(32'h8000_0000, 31);
      eject(32'hC000_0100, 8);
      chk("R6 all ejects seen", exp_q.size(), 0);

      // same-cycle precedence
      @(negedge clk);
      hp_addr = 4'h0; hp_wdata = 32'hFFFF; hp_wr = 1'b1;
      evt_slot = 5'd2; evt_kind = 2'd1; evt_valid = 1'b1;
      gpe_addr = 2'd0; gpe_wdata = 8'h02; gpe_wr = 1'b1;
      @(negedge clk);
      hp_wr = 1'b0; evt_valid = 1'b0; gpe_wr = 1'b0;
      rd_hp(4'h0, 32'h0000_0004, "R10 event beats write");
      rd_gpe(2'd0, 8'h02, "R10 event beats w1c");
      chk("R10 irq", {31'h0, irq}, 32'h1);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule